// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This core runs an eight-instruction integer subset and finishes every instruction in one clock cycle. In one cycle the program counter fetches a word from a private instruction store. The control decoder turns the opcode and function fields into datapath selects. The register file supplies two operands to the ALU. Data memory is read or written at the address the ALU computes. A result is written back, and the next PC is chosen from two candidates. The first is formed by a dedicated increment adder and the second by a separate branch-target adder. The instruction store and the data store are separate arrays, and the PC has its own adders, so no unit is needed twice in one cycle.

The core has no bus to the outside. While reset is held, a testbench or loader fills both memories through a valid/ready preload stream. The rule for back-pressure is simple: `pl_ready` is high exactly while `rst` is high. A word is taken on each rising edge where `pl_valid` and `pl_ready` are both high, and nothing is taken while the core runs. After reset is released, the core executes from address 0. A debug tap shows the current PC. A third, combinational register read port is driven by `dbg_reg_sel`.

Top module: `mcore_top`

## Requirements
- R1: While `rst` is high, at every rising edge, the PC becomes 0 and all 32 registers become 0. `pl_ready` equals `rst`.
- R2: A preload beat (`pl_valid` and `pl_ready` high at a rising edge) writes `pl_data` to word `pl_addr`. When `pl_to_dmem` is 1 it goes to data memory, and when it is 0 it goes to instruction memory.
- R3: Instruction fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0]. Opcode 000000 is register format. With funct 0x20 it writes rs+rt to rd, and with funct 0x22 it writes rs-rt to rd.
- R4: Register format with funct 0x24 writes rs AND rt to rd. With funct 0x25 it writes rs OR rt to rd.
- R5: Register format with funct 0x2A writes 1 to rd when rs < rt as signed 32-bit values, and writes 0 otherwise.
- R6: Opcode 100011 loads into rt the data word at rs + sign-extended imm[15:0]. Memories use byte address bits [AW+1:2].
- R7: Opcode 101011 stores rt to data memory at rs + sign-extended imm[15:0] and writes no register.
- R8: Opcode 000100 compares rs with rt. When they are equal, the next PC is PC+4+(sign-extended imm << 2). When they differ, the next PC is PC+4. No register is written.
- R9: Every instruction other than a taken branch advances the PC by 4.
- R10: Register 0 reads as 0. A write to it has no effect.
- R11: Any opcode not listed above writes no register and no memory, and only advances the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset; also opens the preload stream |
| pl_valid | input | 1 | Preload beat offered |
| pl_ready | output | 1 | Preload beat accepted (high during reset) |
| pl_to_dmem | input | 1 | 1 selects data memory, 0 selects instruction memory |
| pl_addr | input | PL_AW | Word index of the preload beat |
| pl_data | input | 32 | Preload word |
| dbg_pc | output | 32 | Current program counter |
| dbg_reg_sel | input | 5 | Register number for the debug read |
| dbg_reg_data | output | 32 | Contents of the selected register |

## Verification
The arithmetic program loads operands from data memory. They are chosen so that AND and OR give different bit patterns and so that a signed compare gives a different answer from an unsigned one. It then stores a result and reads it back through a base register with a negative offset, which tells correct sign extension apart from zero extension. A write to register 0 and an undefined opcode aimed at a live register show whether writes are suppressed. A second program runs one branch that is taken and one that is not, and checks the PC cycle by cycle. This separates a correct target from PC+4 and catches an off-by-one in the offset scaling.

// File: rtl/mcore_pkg.sv
package mcore_pkg;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  localparam logic [5:0] OP_REG  = 6'b000000;
  localparam logic [5:0] OP_LOAD = 6'b100011;
  localparam logic [5:0] OP_STOR = 6'b101011;
  localparam logic [5:0] OP_BREQ = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef struct packed {
    logic    reg_we;
    logic    dst_is_rd;
    logic    use_imm;
    logic    mem_we;
    logic    wb_from_mem;
    logic    branch;
    alu_op_e alu_op;
  } ctl_t;

endpackage

// File: rtl/mcore_ctrl.sv
module mcore_ctrl
  import mcore_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctl_t       ctl
);

  always_comb begin
    ctl = '{reg_we: 1'b0, dst_is_rd: 1'b0, use_imm: 1'b0, mem_we: 1'b0,
            wb_from_mem: 1'b0, branch: 1'b0, alu_op: ALU_ADD};
    unique case (op)
      OP_REG: begin
        ctl.dst_is_rd = 1'b1;
        ctl.reg_we    = 1'b1;
        case (funct)
          FN_ADD:  ctl.alu_op = ALU_ADD;
          FN_SUB:  ctl.alu_op = ALU_SUB;
          FN_AND:  ctl.alu_op = ALU_AND;
          FN_OR:   ctl.alu_op = ALU_OR;
          FN_SLT:  ctl.alu_op = ALU_SLT;
          default: ctl.reg_we = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctl.reg_we      = 1'b1;
        ctl.use_imm     = 1'b1;
        ctl.wb_from_mem = 1'b1;
      end
      OP_STOR: begin
        ctl.use_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      OP_BREQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end

  // R7/R8: a store or branch never also writes a register
  always_comb begin
    assert_store_no_wb_R7: assert (!(ctl.mem_we && ctl.reg_we));
    assert_branch_no_wb_R8: assert (!(ctl.branch && (ctl.reg_we || ctl.mem_we)));
  end

endmodule

// File: rtl/mcore_alu.sv
module mcore_alu
  import mcore_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/mcore_regfile.sv
module mcore_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RAW-1:0] wa,
  input  logic [W-1:0]   wd,
  input  logic [RAW-1:0] ra1,
  input  logic [RAW-1:0] ra2,
  input  logic [RAW-1:0] ra3,
  output logic [W-1:0]   rd1,
  output logic [W-1:0]   rd2,
  output logic [W-1:0]   rd3
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
  assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

  // R10: a write to a nonzero register is visible on the next cycle
  assert_write_lands_R10: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));

endmodule

// File: rtl/mcore_top.sv
module mcore_top
  import mcore_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int PL_AW   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pl_valid,
  output logic             pl_ready,
  input  logic             pl_to_dmem,
  input  logic [PL_AW-1:0] pl_addr,
  input  logic [31:0]      pl_data,
  output logic [31:0]      dbg_pc,
  input  logic [4:0]       dbg_reg_sel,
  output logic [31:0]      dbg_reg_data
);

  localparam int W      = 32;
  localparam int IWORDS = 1 << IMEM_AW;
  localparam int DWORDS = 1 << DMEM_AW;

  logic [W-1:0] imem [IWORDS];
  logic [W-1:0] dmem [DWORDS];
  logic [W-1:0] pc_q, pc_next, pc_inc, br_target, instr;
  logic [W-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, load_val, wb_val;
  logic [4:0]   wb_reg;
  logic         alu_zero, pl_fire, take_br;
  ctl_t         ctl;

  assign pl_ready = rst;
  assign pl_fire  = pl_valid && pl_ready;

  // fetch and next-PC selection
  assign instr     = imem[pc_q[IMEM_AW+1:2]];
  assign pc_inc    = pc_q + 32'd4;
  assign imm_ext   = {{(W-16){instr[15]}}, instr[15:0]};
  assign br_target = pc_inc + {imm_ext[W-3:0], 2'b00};
  assign take_br   = ctl.branch && alu_zero;
  assign pc_next   = take_br ? br_target : pc_inc;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (pl_fire && !pl_to_dmem) imem[pl_addr[IMEM_AW-1:0]] <= pl_data;
  end

  mcore_ctrl u_ctrl (
    .op    (instr[31:26]),
    .funct (instr[5:0]),
    .ctl   (ctl)
  );

  assign wb_reg = ctl.dst_is_rd ? instr[15:11] : instr[20:16];

  mcore_regfile #(.W(W), .NREG(32)) u_rf (
    .clk (clk),
    .rst (rst),
    .we  (ctl.reg_we && !rst),
    .wa  (wb_reg),
    .wd  (wb_val),
    .ra1 (instr[25:21]),
    .ra2 (instr[20:16]),
    .ra3 (dbg_reg_sel),
    .rd1 (rs_val),
    .rd2 (rt_val),
    .rd3 (dbg_reg_data)
  );

  assign alu_b = ctl.use_imm ? imm_ext : rt_val;

  mcore_alu #(.W(W)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (ctl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: preload port during reset, store path otherwise
  always_ff @(posedge clk) begin
    if (pl_fire && pl_to_dmem)
      dmem[pl_addr[DMEM_AW-1:0]] <= pl_data;
    else if (!rst && ctl.mem_we)
      dmem[alu_y[DMEM_AW+1:2]] <= rt_val;
  end

  assign load_val = dmem[alu_y[DMEM_AW+1:2]];
  assign wb_val   = ctl.wb_from_mem ? load_val : alu_y;
  assign dbg_pc   = pc_q;

  // R9: anything but a taken branch steps the PC by one word
  assert_pc_step_R9: assert property (@(posedge clk) disable iff (rst)
    !(ctl.branch && alu_zero) |=> (dbg_pc == $past(pc_q) + 32'd4));

  // R8: a taken branch lands on the target adder's output
  assert_branch_target_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl.branch && alu_zero) |=> (dbg_pc == $past(br_target)));

  // R1: the PC stays word aligned once running
  assert_pc_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    dbg_pc[1:0] == 2'b00);

endmodule

// File: tb/tb_mcore_top.sv
module tb_mcore_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pl_valid = 1'b0;
  logic        pl_ready;
  logic        pl_to_dmem = 1'b0;
  logic [7:0]  pl_addr = '0;
  logic [31:0] pl_data = '0;
  logic [31:0] dbg_pc;
  logic [4:0]  dbg_reg_sel = '0;
  logic [31:0] dbg_reg_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mcore_top dut (
    .clk(clk), .rst(rst), .pl_valid(pl_valid), .pl_ready(pl_ready),
    .pl_to_dmem(pl_to_dmem), .pl_addr(pl_addr), .pl_data(pl_data),
    .dbg_pc(dbg_pc), .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data)
  );

  function automatic logic [31:0] rfmt(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] ifmt(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_reg(input string req, input int r, input logic [31:0] exp);
    dbg_reg_sel = r[4:0];
    #1;
    check(req, dbg_reg_data, exp);
  endtask

  task automatic push(input bit to_d, input int addr, input logic [31:0] data);
    @(negedge clk);
    pl_valid = 1'b1; pl_to_dmem = to_d; pl_addr = addr[7:0]; pl_data = data;
    @(negedge clk);
    pl_valid = 1'b0;
  endtask

  task automatic enter_reset;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic leave_reset;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset;
    enter_reset();
    check("R1 pc in reset", dbg_pc, 32'd0);
    check("R1 ready in reset", {31'd0, pl_ready}, 32'd1);
    check_reg("R1 reg cleared", 5, 32'd0);
  endtask

  task automatic test_arith;
    int idx;
    logic [31:0] prog [17];
    enter_reset();
    prog[0]  = ifmt(6'b100011, 0, 1, 16'd0);
    prog[1]  = ifmt(6'b100011, 0, 2, 16'd4);
    prog[2]  = ifmt(6'b100011, 0, 3, 16'd8);
    prog[3]  = ifmt(6'b100011, 0, 4, 16'd12);
    prog[4]  = rfmt(1, 2, 5, 6'h20);
    prog[5]  = rfmt(1, 2, 6, 6'h22);
    prog[6]  = rfmt(3, 4, 7, 6'h24);
    prog[7]  = rfmt(3, 4, 8, 6'h25);
    prog[8]  = rfmt(2, 1, 9, 6'h2A);
    prog[9]  = rfmt(1, 2, 10, 6'h2A);
    prog[10] = rfmt(1, 1, 0, 6'h20);
    prog[11] = ifmt(6'b101011, 0, 5, 16'd16);
    prog[12] = ifmt(6'b100011, 0, 11, 16'd16);
    prog[13] = ifmt(6'b100011, 0, 13, 16'd20);
    prog[14] = ifmt(6'b100011, 13, 14, 16'hFFF8);
    prog[15] = ifmt(6'b111111, 0, 1, 16'h1234);
    prog[16] = ifmt(6'b000100, 0, 0, 16'hFFFF);
    for (int i = 0; i < 17; i++) push(1'b0, i, prog[i]);
    push(1'b1, 0, 32'd5);
    push(1'b1, 1, 32'hFFFF_FFFD);
    push(1'b1, 2, 32'h0F0F_00FF);
    push(1'b1, 3, 32'h00FF_0F0F);
    push(1'b1, 5, 32'd24);
    leave_reset();
    idx = 0;
    run(1);
    check("R2 ready low when running", {31'd0, pl_ready}, 32'd0);
    run(24);
    check_reg("R3 add", 5, 32'd2);
    check_reg("R3 sub", 6, 32'd8);
    check_reg("R4 and", 7, 32'h000F_000F);
    check_reg("R4 or", 8, 32'h0FFF_0FFF);
    check_reg("R5 slt signed true", 9, 32'd1);
    check_reg("R5 slt false", 10, 32'd0);
    check_reg("R10 r0 stays zero", 0, 32'd0);
    check_reg("R7 store then load", 11, 32'd2);
    check_reg("R6 load positive offset", 13, 32'd24);
    check_reg("R6 load negative offset", 14, 32'd2);
    check_reg("R11 undefined op no write", 1, 32'd5);
    check("R8 halt loop pc", dbg_pc, 32'd64);
  endtask

  task automatic test_branch;
    logic [31:0] prog [9];
    enter_reset();
    prog[0] = ifmt(6'b100011, 0, 1, 16'd0);
    prog[1] = ifmt(6'b100011, 0, 2, 16'd4);
    prog[2] = ifmt(6'b100011, 0, 3, 16'd8);
    prog[3] = ifmt(6'b000100, 1, 2, 16'd2);
    prog[4] = rfmt(1, 1, 4, 6'h20);
    prog[5] = rfmt(1, 1, 4, 6'h20);
    prog[6] = ifmt(6'b000100, 1, 3, 16'd1);
    prog[7] = rfmt(1, 3, 5, 6'h20);
    prog[8] = ifmt(6'b000100, 0, 0, 16'hFFFF);
    for (int i = 0; i < 9; i++) push(1'b0, i, prog[i]);
    push(1'b1, 0, 32'd7);
    push(1'b1, 1, 32'd7);
    push(1'b1, 2, 32'd9);
    leave_reset();
    check("R1 pc after release", dbg_pc, 32'd0);
    run(3);
    check("R9 pc after loads", dbg_pc, 32'd12);
    run(1);
    check("R8 taken branch target", dbg_pc, 32'd24);
    run(1);
    check("R8 untaken branch", dbg_pc, 32'd28);
    run(1);
    check("R9 pc after add", dbg_pc, 32'd32);
    run(1);
    check("R8 self loop holds", dbg_pc, 32'd32);
    check_reg("R8 skipped instructions", 4, 32'd0);
    check_reg("R3 add after branch", 5, 32'd16);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    test_reset();
    test_arith();
    test_branch();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

endmodule